// File: doc/BRIEF.md
# Synchronizable Decimator Output Sequencer

This block is the digital output stage of an oversampling converter. A sequencer counter divides the master clock into output-word periods of `DEC_RATIO` cycles. At the end of each period the block loads the current filtered sample word into a 16-bit output register. Before each load, a ready strobe is driven high for the last two clocks of the period, and it falls on the same edge that updates the register. A host can latch data on the strobe's rising edge or take an interrupt on its falling edge.

A synchronization input lets several instances on a common master clock start counting on the same edge, so that they update their outputs together. Each instance first passes the sync line through a two-flop synchronizer. While the synchronized sync level is high, the sequencer is held at zero. Counting restarts on the first edge that samples the synchronized level low. After a sync, and after reset, the block discards `SETTLE_WORDS` word periods while the filter settles. The strobe stays high without interruption until the first valid word is loaded.

Top module: `dec_out_seq`

## Requirements
- R1: While rst_ni is low, drdy_o is 1 and data_o is 0.
- R2: In steady state, drdy_o falls exactly once every DEC_RATIO clocks. In each period it is high for exactly the two cycles just before the fall, and low otherwise.
- R3: data_o changes only on the rising edge at which drdy_o falls. On that edge it takes the value sample_i has at that edge.
- R4: Suppose sync_i is a one-cycle pulse that is first sampled high at clock edge k. Then drdy_o is high from edge k+1 on, and its next fall occurs at edge k+2+(SETTLE_WORDS+1)*DEC_RATIO.
- R5: After reset release, counting edges from the first edge after release as edge 1, drdy_o stays high continuously until its first fall at edge (SETTLE_WORDS+1)*DEC_RATIO. No low pulse is issued during settling.
- R6: While sync_i is held high for many cycles, drdy_o stays high and data_o holds its value. If edge k is the last edge that samples sync_i high, the next fall of drdy_o is at edge k+2+(SETTLE_WORDS+1)*DEC_RATIO.
- R7: Two instances on one clock that receive the same sync pulse have identical drdy_o from two edges after the pulse onward. Their data_o is identical after the first fall, given the same sample_i.
- R8: A sync pulse that arrives during settling restarts the full settling interval, measured from the new pulse as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Synchronization request, asynchronous to clk_i |
| sample_i | input | DATA_W | Filtered sample word offered for loading |
| drdy_o | output | 1 | Data-ready strobe, falls when a new word is loaded |
| data_o | output | DATA_W | Output data register |

## Verification
The checker watches four rules on every cycle. The register changes only on a falling strobe. The strobe is never high or low for just a single cycle in isolation. A sync sampled two cycles earlier forces the strobe high. That same sync freezes the register on the following edge. The timing of the first valid word after reset or after a sync, a restart of settling, the exact period and high width, and the lockstep of two instances span hundreds of cycles. Only the bench scenarios show these, through a cycle-accurate reference model and counts of edges between falls.

// File: rtl/dos_pkg.sv
package dos_pkg;
  localparam int DOS_DATA_W      = 16;
  localparam int DOS_DEC_RATIO   = 32;
  localparam int DOS_SETTLE      = 4;
  localparam int DOS_SYNC_STAGES = 2;
endpackage

// File: rtl/dos_sync.sv
module dos_sync #(
  parameter int STAGES = dos_pkg::DOS_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= async_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign lvl_o = ff_q[STAGES-1];
endmodule

// File: rtl/dos_seq.sv
module dos_seq #(
  parameter int DEC_RATIO = dos_pkg::DOS_DEC_RATIO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic wrap_o,
  output logic late_o
);
  localparam int CNT_W = $clog2(DEC_RATIO);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEC_RATIO - 1);
  localparam logic [CNT_W-1:0] WARN = CNT_W'(DEC_RATIO - 2);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || at_last) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;

  assign wrap_o = at_last & ~hold_i;
  // strobe window: last two counts of the period
  assign late_o = (cnt_q >= WARN);
endmodule

// File: rtl/dos_out.sv
module dos_out #(
  parameter int DATA_W       = dos_pkg::DOS_DATA_W,
  parameter int SETTLE_WORDS = dos_pkg::DOS_SETTLE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              wrap_i,
  input  logic              late_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              drdy_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int SET_W = $clog2(SETTLE_WORDS + 2);
  localparam logic [SET_W-1:0] SET_INIT = SET_W'(SETTLE_WORDS);

  logic [SET_W-1:0]  left_q;
  logic              primed_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      left_q   <= SET_INIT;
      primed_q <= 1'b0;
    end else if (hold_i) begin
      left_q   <= SET_INIT;
      primed_q <= 1'b0;
    end else if (wrap_i) begin
      if (left_q != '0) left_q   <= left_q - 1'b1;
      else              primed_q <= 1'b1;
    end

  // load only once settling has drained
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                         data_q <= '0;
    else if (wrap_i && (left_q == '0))   data_q <= sample_i;

  assign drdy_o = hold_i | ~primed_q | late_i;
  assign data_o = data_q;
endmodule

// File: rtl/dec_out_seq.sv
module dec_out_seq #(
  parameter int DATA_W       = dos_pkg::DOS_DATA_W,
  parameter int DEC_RATIO    = dos_pkg::DOS_DEC_RATIO,
  parameter int SETTLE_WORDS = dos_pkg::DOS_SETTLE,
  parameter int SYNC_STAGES  = dos_pkg::DOS_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              drdy_o,
  output logic [DATA_W-1:0] data_o
);
  logic hold;
  logic wrap;
  logic late;

  dos_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_i),
    .lvl_o  (hold)
  );

  dos_seq #(.DEC_RATIO(DEC_RATIO)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .wrap_o(wrap),
    .late_o(late)
  );

  dos_out #(.DATA_W(DATA_W), .SETTLE_WORDS(SETTLE_WORDS)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold),
    .wrap_i  (wrap),
    .late_i  (late),
    .sample_i(sample_i),
    .drdy_o  (drdy_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/dec_out_seq_chk.sv
module dec_out_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              drdy_o,
  input logic [DATA_W-1:0] data_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (drdy_o && data_o == '0));

  // R2
  drdy_high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |=> drdy_o);

  // R2
  drdy_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_o) |=> !drdy_o);

  // R3
  data_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $fell(drdy_o));

  // R4
  sync_forces_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_i, 2) |-> drdy_o);

  // R6
  sync_freezes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_i, 2) |=> $stable(data_o));
endmodule

bind dec_out_seq dec_out_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sync_i(sync_i),
  .drdy_o(drdy_o),
  .data_o(data_o)
);

// File: tb/dec_out_seq_bench.sv
`timescale 1ns/1ps
module dec_out_seq_bench;
  localparam int DW  = 16;
  localparam int DEC = 32;
  localparam int SET = 4;
  localparam int LAT = (SET + 1) * DEC;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sync_a = 1'b0;
  logic          sync_b = 1'b0;
  logic [DW-1:0] sample = '0;
  logic          drdy_a, drdy_b;
  logic [DW-1:0] data_a, data_b;
  int            cyc;
  int            n_chk = 0;
  int            n_err = 0;

  always #2 clk = ~clk;

  dec_out_seq #(.DATA_W(DW), .DEC_RATIO(DEC), .SETTLE_WORDS(SET)) u_dec_out_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_a), .sample_i(sample),
    .drdy_o(drdy_a), .data_o(data_a));

  dec_out_seq #(.DATA_W(DW), .DEC_RATIO(DEC), .SETTLE_WORDS(SET)) u_dec_out_seq_b (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_b), .sample_i(sample),
    .drdy_o(drdy_b), .data_o(data_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  always @(negedge clk) sample <= DW'(cyc * 499 + 1445);

  // behavioural reference for instance a
  int            m_cnt, m_left;
  bit            m_s1, m_s2, m_primed;
  logic [DW-1:0] m_data;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_left = SET; m_primed = 0; m_data = '0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (m_s2) begin
        m_cnt = 0; m_left = SET; m_primed = 0;
      end else if (m_cnt == DEC - 1) begin
        m_cnt = 0;
        if (m_left > 0) m_left--;
        else begin m_data = sample; m_primed = 1; end
      end else m_cnt++;
      m_s2 = m_s1;
      m_s1 = sync_a;
    end
  end

  always @(negedge clk) if (rst_ni) begin
    bit exp_drdy;
    exp_drdy = m_s2 || !m_primed || (m_cnt >= DEC - 2);
    chk(drdy_a == exp_drdy, "R2 model drdy", drdy_a, exp_drdy);
    chk(data_a == m_data, "R3 model data", data_a, m_data);
  end

  task automatic wait_fall(input bit sel, output int f, output int highs, output int lows);
    bit p, d;
    p = sel ? drdy_b : drdy_a;
    highs = 0; lows = 0;
    forever begin
      @(negedge clk);
      d = sel ? drdy_b : drdy_a;
      if (p && !d) break;
      if (d) highs++; else lows++;
      p = d;
    end
    f = cyc;
  endtask

  // call at a negedge; returns the edge number that sampled the pulse
  task automatic pulse(input bit on_a, input bit on_b, output int k);
    if (on_a) sync_a = 1'b1;
    if (on_b) sync_b = 1'b1;
    @(negedge clk);
    k = cyc;
    sync_a = 1'b0;
    sync_b = 1'b0;
  endtask

  initial begin
    int f, hi, lo, k, f0;
    logic [DW-1:0] d0;
    bit seen;
    repeat (3) @(negedge clk);
    chk(drdy_a == 1'b1, "R1 drdy in reset", drdy_a, 1);
    chk(data_a == '0, "R1 data in reset", data_a, 0);
    chk(drdy_b == 1'b1, "R1 drdy in reset b", drdy_b, 1);
    rst_ni = 1'b1;

    wait_fall(0, f, hi, lo);
    chk(f == LAT, "R5 first fall edge", f, LAT);
    chk(lo == 0, "R5 no low during settling", lo, 0);

    for (int i = 0; i < 3; i++) begin
      f0 = f;
      wait_fall(0, f, hi, lo);
      chk(f - f0 == DEC, "R2 period", f - f0, DEC);
      chk(hi == 2, "R2 high width", hi, 2);
    end

    pulse(1, 0, k);
    wait_fall(0, f, hi, lo);
    chk(f == k + 2 + LAT, "R4 fall after sync", f, k + 2 + LAT);
    chk(lo == 0, "R4 drdy held high", lo, 0);

    pulse(1, 0, k);
    repeat (2 * DEC) @(negedge clk);
    pulse(1, 0, k);
    wait_fall(0, f, hi, lo);
    chk(f == k + 2 + LAT, "R8 settling restarted", f, k + 2 + LAT);
    chk(lo == 0, "R8 no low pulse", lo, 0);

    d0 = data_a;
    sync_a = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(drdy_a == 1'b1, "R6 drdy during hold", drdy_a, 1);
        chk(data_a == d0, "R6 data frozen", data_a, d0);
      end
    end
    pulse(0, 0, k);
    wait_fall(0, f, hi, lo);
    chk(f == k + 2 + LAT, "R6 release timing", f, k + 2 + LAT);

    pulse(0, 1, k);
    repeat (2 * DEC + 7) @(negedge clk);
    pulse(1, 1, k);
    seen = 0;
    for (int i = 0; i < 6 * DEC; i++) begin
      @(negedge clk);
      chk(drdy_a == drdy_b, "R7 lockstep drdy", drdy_b, drdy_a);
      if (seen) chk(data_a == data_b, "R7 lockstep data", data_b, data_a);
      if (cyc >= k + 2 + LAT) seen = 1;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule